// File: doc/BRIEF.md
# Windowed Memory Access Port

This block lets a host on a byte-wide register bus reach a local memory of 32-bit words through a small window of registers. The host first loads a two-byte address register. That register holds a word address inside a 15-bit byte space and a two-bit access mode. The host then moves data through four byte-wide data registers, one for each byte lane of the addressed word.

Byte mode reaches single lanes of memory directly and leaves the address where it is. Word mode goes through a 32-bit staging register. Reading lane 0 fetches the whole word into the stage. Reading lanes 1 to 3 returns the staged bytes. Writing lanes 0 to 2 fills the stage, and writing lane 3 stores the staged word back to memory. Both the fetch and the store step the address on to the next word. Because of this, the order in which the host touches the lanes decides when memory is accessed.

The memory model holds `MEM_WORDS` words. Word-address bits above its depth alias onto it. Every host read is answered one cycle after the request, with `rvalid_o` high. The host may issue one access per cycle, with no gaps between accesses.

Top module: `win_mem_port`

## Requirements
- R1: Register offsets on `reg_i`: 0 is the low address byte, 1 is the high address byte, and 4+n is data lane n (n = 0..3, bits 8n+7:8n of the word). A read request returns its byte on `rdata_o` with `rvalid_o` high in the cycle after the request. `rvalid_o` is low in every other cycle. Offsets 2 and 3 read as zero, and writes to them have no effect.
- R2: The low address byte is {word address bits 5:0, mode[1:0]}, so byte-address bits 7:2 sit in bits 7:2. The high address byte carries word address bits 12:6 (byte-address bits 14:8) in bits 6:0. Bit 7 of the high byte is ignored on write and reads back as 0. Both bytes can be read back, mode bits included.
- R3: Mode 2'b11 selects 32-bit auto-increment access. Modes 2'b00, 2'b01 and 2'b10 all select byte access.
- R4: In byte mode, a read of lane n returns byte n of the addressed word from memory, and the address does not change.
- R5: In byte mode, a write of lane n updates only byte n of the addressed word, immediately, and the address does not change.
- R6: In word mode, a read of lane 0 loads the addressed word into the stage, returns its byte 0, and advances the word address by one (4 bytes).
- R7: In word mode, reads of lanes 1 to 3 return bytes of the staged word. They leave memory and the address alone.
- R8: In word mode, writes of lanes 0 to 2 change only the stage. Memory is unchanged until lane 3 is written.
- R9: In word mode, a write of lane 3 stores {written byte, staged bytes 2..0} to the addressed word and advances the word address by one.
- R10: Advancing from word address 0x1FFF (byte 0x7FFC) wraps to word address 0.
- R11: A write to either address byte discards the stage: the stage becomes zero, including a fetch from the previous cycle that has not yet landed.
- R12: Reset clears the address, the mode and the stage to zero, and holds `rvalid_o` low.
- R13: An access in the cycle right after a fetch sees the fetched word. A lane read returns its byte, a lane write merges into it, and a lane-3 write stores the merged word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| reg_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte, valid with rvalid_o |
| rvalid_o | output | 1 | Read response strobe, one cycle after a read request |

## Verification
The fetched word reaches the staging register one cycle after the fetch. In that same cycle the host may already read a staged lane, write one, store the word with lane 3, or rewrite the address. In each case the stage load and the new access coincide, and the block must forward the arriving word, merge into it, or drop it. The bench provokes each collision with accesses issued on consecutive cycles straight after a lane-0 read. A behavioural model that applies every access atomically at its request compares `rvalid_o` and `rdata_o` on every clock, and later byte-mode read-back exposes any stored word that was built wrongly.

// File: rtl/win_mem_pkg.sv
package win_mem_pkg;
  localparam int HOST_AW = 15;                // byte address bits of the window
  localparam int WORD_AW = HOST_AW - 2;       // word address bits
  localparam int HI_W    = WORD_AW - 6;       // word bits held in the high address byte
  localparam logic [1:0] MODE_AUTO32 = 2'b11;
  localparam logic [2:0] REG_ADDR_LO = 3'd0;
  localparam logic [2:0] REG_ADDR_HI = 3'd1;

  typedef struct packed {
    logic fetch;
    logic stage_rd;
    logic stage_wr;
    logic commit;
    logic byte_rd;
    logic byte_wr;
    logic lo_wr;
    logic hi_wr;
  } op_t;
endpackage

// File: rtl/win_mem_addr.sv
module win_mem_addr #(
  parameter int WA   = win_mem_pkg::WORD_AW,
  parameter int HI_W = win_mem_pkg::HI_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lo_we_i,
  input  logic            hi_we_i,
  input  logic [7:0]      lo_data_i,
  input  logic [HI_W-1:0] hi_data_i,
  input  logic            adv_i,
  output logic [WA-1:0]   waddr_o,
  output logic [1:0]      mode_o
);
  logic [WA-1:0] waddr_q;
  logic [1:0]    mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      waddr_q <= '0;
      mode_q  <= '0;
    end else if (lo_we_i) begin
      waddr_q[5:0] <= lo_data_i[7:2];
      mode_q       <= lo_data_i[1:0];
    end else if (hi_we_i) begin
      waddr_q[WA-1:6] <= hi_data_i;
    end else if (adv_i) begin
      waddr_q <= waddr_q + 1'b1;   // wraps at the window top
    end
  end

  assign waddr_o = waddr_q;
  assign mode_o  = mode_q;
endmodule

// File: rtl/win_mem_stage.sv
module win_mem_stage (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        commit_i,
  input  logic        lane_we_i,
  input  logic [1:0]  lane_i,
  input  logic [7:0]  wdata_i,
  input  logic        load_i,
  input  logic [31:0] ram_q_i,
  output logic [31:0] view_o,
  output logic [31:0] commit_word_o,
  output logic [31:0] stage_o
);
  logic [3:0][7:0] stage_q, stage_d, view;

  // a fetch lands one cycle late: forward it to any access in that cycle
  assign view          = load_i ? ram_q_i : stage_q;
  assign commit_word_o = {wdata_i, view[2], view[1], view[0]};

  for (genvar l = 0; l < 4; l++) begin : g_lane
    assign stage_d[l] = clr_i                        ? 8'h00 :
                        commit_i                     ? commit_word_o[l*8 +: 8] :
                        (lane_we_i && lane_i == 2'(l)) ? wdata_i :
                        view[l];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  assign view_o  = view;
  assign stage_o = stage_q;
endmodule

// File: rtl/win_mem_ram.sv
module win_mem_ram #(
  parameter int WORDS = 1024,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [3:0]    be_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o
);
  logic [31:0] mem [WORDS];
  logic [31:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) begin
        for (int b = 0; b < 4; b++)
          if (be_i[b]) mem[addr_i][b*8 +: 8] <= wdata_i[b*8 +: 8];
      end else begin
        rdata_q <= mem[addr_i];
      end
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/win_mem_port.sv
module win_mem_port #(
  parameter int MEM_WORDS = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       we_i,
  input  logic [2:0] reg_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       rvalid_o
);
  import win_mem_pkg::*;

  localparam int WA     = WORD_AW;
  localparam int RAM_AW = $clog2(MEM_WORDS);

  op_t         op;
  logic [1:0]  lane, mode_q;
  logic        auto_m, is_data;
  logic [WA-1:0] waddr_q;
  logic [31:0] ram_q, view, commit_word, stage_q;
  logic        ram_en, ram_we;
  logic [3:0]  ram_be;
  logic [31:0] ram_wdata;
  logic        pend_q, rvalid_q, resp_ram_q;
  logic [1:0]  resp_lane_q;
  logic [7:0]  resp_q, rd_byte, addr_lo, addr_hi;

  assign lane    = reg_i[1:0];
  assign auto_m  = (mode_q == MODE_AUTO32);
  assign is_data = req_i && reg_i[2];

  always_comb begin
    op          = '0;
    op.fetch    = is_data && !we_i &&  auto_m && lane == 2'd0;
    op.stage_rd = is_data && !we_i &&  auto_m && lane != 2'd0;
    op.stage_wr = is_data &&  we_i &&  auto_m && lane != 2'd3;
    op.commit   = is_data &&  we_i &&  auto_m && lane == 2'd3;
    op.byte_rd  = is_data && !we_i && !auto_m;
    op.byte_wr  = is_data &&  we_i && !auto_m;
    op.lo_wr    = req_i && we_i && reg_i == REG_ADDR_LO;
    op.hi_wr    = req_i && we_i && reg_i == REG_ADDR_HI;
  end

  win_mem_addr #(.WA(WA), .HI_W(HI_W)) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lo_we_i   (op.lo_wr),
    .hi_we_i   (op.hi_wr),
    .lo_data_i (wdata_i),
    .hi_data_i (wdata_i[HI_W-1:0]),
    .adv_i     (op.fetch || op.commit),
    .waddr_o   (waddr_q),
    .mode_o    (mode_q)
  );

  win_mem_stage u_stage (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clr_i         (op.lo_wr || op.hi_wr),
    .commit_i      (op.commit),
    .lane_we_i     (op.stage_wr),
    .lane_i        (lane),
    .wdata_i       (wdata_i),
    .load_i        (pend_q),
    .ram_q_i       (ram_q),
    .view_o        (view),
    .commit_word_o (commit_word),
    .stage_o       (stage_q)
  );

  assign ram_en    = op.fetch || op.commit || op.byte_rd || op.byte_wr;
  assign ram_we    = op.commit || op.byte_wr;
  assign ram_be    = op.commit ? 4'hF : (4'h1 << lane);
  assign ram_wdata = op.commit ? commit_word : {4{wdata_i}};

  win_mem_ram #(.WORDS(MEM_WORDS), .AW(RAM_AW)) u_ram (
    .clk_i   (clk_i),
    .en_i    (ram_en),
    .we_i    (ram_we),
    .be_i    (ram_be),
    .addr_i  (waddr_q[RAM_AW-1:0]),
    .wdata_i (ram_wdata),
    .rdata_o (ram_q)
  );

  assign addr_lo = {waddr_q[5:0], mode_q};
  assign addr_hi = {{(8-HI_W){1'b0}}, waddr_q[WA-1:6]};

  always_comb begin
    rd_byte = 8'h00;
    if (reg_i == REG_ADDR_LO)      rd_byte = addr_lo;
    else if (reg_i == REG_ADDR_HI) rd_byte = addr_hi;
    else if (op.stage_rd)          rd_byte = view[lane*8 +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      rvalid_q    <= 1'b0;
      resp_ram_q  <= 1'b0;
      resp_lane_q <= '0;
      resp_q      <= '0;
    end else begin
      pend_q      <= op.fetch;
      rvalid_q    <= req_i && !we_i;
      resp_ram_q  <= op.fetch || op.byte_rd;
      resp_lane_q <= lane;
      resp_q      <= rd_byte;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = resp_ram_q ? ram_q[resp_lane_q*8 +: 8] : resp_q;
endmodule

// File: rtl/win_mem_port_chk.sv
module win_mem_port_chk #(
  parameter int WA = 13
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic [2:0]    reg_i,
  input logic          rvalid_o,
  input logic [WA-1:0] waddr_q,
  input logic [1:0]    mode_q,
  input logic [31:0]   stage_q,
  input logic          ram_we,
  input logic [3:0]    ram_be
);
  p_rvalid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  p_no_rvalid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);

  p_byte_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && reg_i[2] && mode_q != 2'b11) |=> $stable(waddr_q));

  p_fetch_adv_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && reg_i == 3'd4 && mode_q == 2'b11)
      |=> waddr_q == WA'($past(waddr_q) + 1'b1));

  p_stage_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && reg_i[2] && reg_i[1:0] != 2'd3 && mode_q == 2'b11) |-> !ram_we);

  p_commit_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we && mode_q == 2'b11) |-> ram_be == 4'hF);

  p_discard_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && reg_i[2:1] == 2'b00) |=> stage_q == 32'h0);
endmodule

bind win_mem_port win_mem_port_chk #(.WA(WA)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .reg_i    (reg_i),
  .rvalid_o (rvalid_o),
  .waddr_q  (waddr_q),
  .mode_q   (mode_q),
  .stage_q  (stage_q),
  .ram_we   (ram_we),
  .ram_be   (ram_be)
);

// File: tb/win_mem_port_test.sv
`timescale 1ns/1ps
module win_mem_port_test;
  localparam int MW = 1024;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0;
  logic [2:0] rg = '0;
  logic [7:0] wd = '0;
  logic [7:0] rdata;
  logic       rvalid;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference state
  logic [12:0] m_addr;
  logic [1:0]  m_mode;
  logic [31:0] m_stage;
  logic [31:0] m_mem [MW];

  always #2.5 clk = ~clk;

  win_mem_port #(.MEM_WORDS(MW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .reg_i(rg), .wdata_i(wd), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model(input bit r, input bit w, input logic [2:0] o, input logic [7:0] d,
                       output bit ev, output logic [7:0] ed);
    int idx;
    idx = int'(m_addr) % MW;
    ev = r && !w;
    ed = 8'h00;
    if (!r) return;
    if (o == 3'd0) begin
      if (w) begin m_addr[5:0] = d[7:2]; m_mode = d[1:0]; m_stage = 0; end
      else ed = {m_addr[5:0], m_mode};
    end else if (o == 3'd1) begin
      if (w) begin m_addr[12:6] = d[6:0]; m_stage = 0; end
      else ed = {1'b0, m_addr[12:6]};
    end else if (o[2]) begin
      if (m_mode == 2'b11) begin
        if (w) begin
          m_stage[o[1:0]*8 +: 8] = d;
          if (o[1:0] == 2'd3) begin m_mem[idx] = m_stage; m_addr = m_addr + 1'b1; end
        end else begin
          if (o[1:0] == 2'd0) begin m_stage = m_mem[idx]; m_addr = m_addr + 1'b1; end
          ed = m_stage[o[1:0]*8 +: 8];
        end
      end else begin
        if (w) m_mem[idx][o[1:0]*8 +: 8] = d;
        else   ed = m_mem[idx][o[1:0]*8 +: 8];
      end
    end
  endtask

  // one bus cycle, compared against the model after the edge
  task automatic cyc(input bit r, input bit w, input logic [2:0] o, input logic [7:0] d, input string tag);
    bit ev;
    logic [7:0] ed;
    @(negedge clk);
    req = r; we = w; rg = o; wd = d;
    model(r, w, o, d, ev, ed);
    @(posedge clk);
    #1;
    req = 1'b0;
    chk(rvalid === ev, {tag, " rvalid"}, 32'(rvalid), 32'(ev));
    if (ev) chk(rdata === ed, {tag, " rdata"}, 32'(rdata), 32'(ed));
  endtask

  task automatic wr(input logic [2:0] o, input logic [7:0] d, input string tag);
    cyc(1'b1, 1'b1, o, d, tag);
  endtask
  task automatic rd(input logic [2:0] o, input string tag);
    cyc(1'b1, 1'b0, o, 8'h00, tag);
  endtask
  task automatic set_addr(input logic [12:0] a, input logic [1:0] md, input string tag);
    wr(3'd1, {1'b0, a[12:6]}, tag);
    wr(3'd0, {a[5:0], md}, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = 1'b0;
    m_addr = '0; m_mode = '0; m_stage = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MW; i++) m_mem[i] = '0;
    do_reset();
    // R12 reset state, R2 readback
    rd(3'd0, "R12 addr lo after reset");
    rd(3'd1, "R12 addr hi after reset");
    cyc(1'b0, 1'b0, 3'd0, 8'h00, "R12 idle rvalid");

    // clear words 0..7 via word-mode commits (R9)
    set_addr(13'd0, 2'b11, "R2 set");
    for (int i = 0; i < 32; i++) wr(3'(4 + i % 4), 8'h00, "R9 fill");
    rd(3'd0, "R9 address after 8 commits");

    // byte mode (R5, R4)
    set_addr(13'd0, 2'b00, "R3 byte mode");
    wr(3'd4, 8'h11, "R5"); wr(3'd5, 8'h22, "R5"); wr(3'd6, 8'h33, "R5"); wr(3'd7, 8'h44, "R5");
    rd(3'd6, "R4 lane2"); rd(3'd4, "R4 lane0"); rd(3'd7, "R4 lane3");
    rd(3'd0, "R4 no advance");

    // modes 01 and 10 behave as byte mode (R3)
    set_addr(13'd1, 2'b01, "R3 mode01");
    wr(3'd6, 8'h5A, "R3 mode01 write");
    rd(3'd6, "R3 mode01 read"); rd(3'd4, "R3 mode01 other lane");
    set_addr(13'd1, 2'b10, "R3 mode10");
    wr(3'd5, 8'hC3, "R3 mode10 write");
    rd(3'd5, "R3 mode10 read"); rd(3'd0, "R3 mode10 no advance");

    // R8: partial staging never reaches memory
    set_addr(13'd4, 2'b11, "R8 word mode");
    wr(3'd4, 8'hE0, "R8"); wr(3'd5, 8'hE1, "R8"); wr(3'd6, 8'hE2, "R8");
    rd(3'd0, "R8 address unchanged");
    set_addr(13'd4, 2'b00, "R8 byte view");
    rd(3'd4, "R8 memory untouched"); rd(3'd6, "R8 memory untouched");

    // R9 commit at word 2
    set_addr(13'd2, 2'b11, "R9 set");
    wr(3'd4, 8'hA0, "R9"); wr(3'd5, 8'hA1, "R9"); wr(3'd6, 8'hA2, "R9"); wr(3'd7, 8'hA3, "R9 commit");
    rd(3'd0, "R9 advanced");

    // R6 R7 R13 fetch then back-to-back staged reads
    set_addr(13'd0, 2'b11, "R6 set");
    rd(3'd4, "R6 fetch lane0"); rd(3'd5, "R13 lane1 after fetch");
    rd(3'd6, "R7 lane2"); rd(3'd7, "R7 lane3"); rd(3'd5, "R7 lane1 again");
    rd(3'd0, "R7 address after one fetch");
    // streaming reads across words
    for (int i = 0; i < 12; i++) rd(3'(4 + i % 4), "R6 stream");

    // R13 fetch, merge write next cycle, then commit
    set_addr(13'd2, 2'b11, "R13 set");
    rd(3'd4, "R13 fetch"); wr(3'd5, 8'h55, "R13 merge"); wr(3'd7, 8'h66, "R13 commit");
    set_addr(13'd3, 2'b00, "R13 view");
    for (int i = 0; i < 4; i++) rd(3'(4 + i), "R13 stored word");

    // R11 fetch immediately followed by address write
    set_addr(13'd0, 2'b11, "R11 set");
    wr(3'd1, 8'h00, "R11 hi");
    rd(3'd4, "R11 fetch");
    wr(3'd0, {6'd5, 2'b11}, "R11 discard");
    rd(3'd6, "R11 stage cleared"); rd(3'd5, "R11 stage cleared");
    wr(3'd7, 8'h77, "R11 commit zeros");
    set_addr(13'd5, 2'b00, "R11 view");
    for (int i = 0; i < 4; i++) rd(3'(4 + i), "R11 stored word");

    // R10 wrap, R2 bit 7 ignored
    wr(3'd1, 8'hFF, "R2 hi bit7");
    wr(3'd0, 8'hFF, "R10 set");
    rd(3'd1, "R2 hi readback"); rd(3'd0, "R2 lo readback");
    wr(3'd4, 8'h91, "R10"); wr(3'd5, 8'h92, "R10"); wr(3'd6, 8'h93, "R10"); wr(3'd7, 8'h94, "R10 commit");
    rd(3'd0, "R10 wrapped lo"); rd(3'd1, "R10 wrapped hi");
    set_addr(13'h1FFF, 2'b00, "R10 view");
    rd(3'd7, "R10 top word"); rd(3'd4, "R10 top word");

    // R1 unused offsets
    wr(3'd2, 8'hFF, "R1 off2 write"); wr(3'd3, 8'hFF, "R1 off3 write");
    rd(3'd2, "R1 off2 read"); rd(3'd3, "R1 off3 read");
    rd(3'd0, "R1 address intact"); rd(3'd1, "R1 address intact");

    // R12 reset mid-run
    set_addr(13'h0ABC, 2'b11, "R12 pre");
    do_reset();
    rd(3'd0, "R12 lo cleared"); rd(3'd1, "R12 hi cleared");
    rd(3'd4, "R12 byte mode after reset");

    repeat (2) cyc(1'b0, 1'b0, 3'd0, 8'h00, "R1 idle");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule